// File: doc/BRIEF.md
# Double-Precision Exponent Extraction Unit

This unit takes one 64-bit binary64 operand and returns, one clock later, a binary64 word that holds floor(log2(|x|)) as an exact whole number. For normal operands that number is the stored exponent with the bias removed. Subnormal operands are first normalized with a leading-zero count on their fraction, so that they give their true (more negative) exponent. The sign of the operand plays no part in a numeric result.

The special operands have fixed answers. Infinities give +infinity and zeros give -infinity. A NaN comes back quieted, and the invalid flag marks a signaling NaN. A denormals-as-zero control makes the unit treat every zero-exponent operand as zero. A denormal flag reports that a subnormal operand was normalized. Both flags describe only the operand of the same cycle. Because the integer always lies within [-1074, +1023], the conversion back to binary64 needs no rounding.

Top module: `dexp_unit`

## Requirements
- R1: For an operand whose exponent field e (bits 62:52) is neither 0 nor 2047, the result is the binary64 encoding of the integer e - 1023, with no rounding.
- R2: The operand's sign bit (bit 63) has no effect on the result or on the flags for any non-NaN operand. A numeric result is negative exactly when the exponent field is below 1023.
- R3: For a NaN operand (e = 2047, fraction nonzero), the result is the operand with bit 51 forced to 1, keeping its sign and payload. The invalid flag is 1 exactly when bit 51 of the operand was 0.
- R4: An infinite operand (e = 2047, fraction 0) of either sign gives 64'h7FF0000000000000.
- R5: An operand with e = 0 and fraction 0 gives 64'hFFF0000000000000 with both flags low.
- R6: With denormals-as-zero low, an operand with e = 0 and a nonzero fraction gives the binary64 value of -1023 minus the count of leading zeros in the 52-bit fraction, and raises the denormal flag.
- R7: With denormals-as-zero high, any operand with e = 0 gives 64'hFFF0000000000000 and the denormal flag stays low.
- R8: An operand with e = 1023 gives the all-zero word (+0.0).
- R9: The flags are not sticky. Each reflects only the operand applied in the same cycle, and an operand that does not raise a flag leaves it low.
- R10: The result and the flags are registered, so they appear on the clock edge after the operand is applied. Reset clears the result and both flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_in | input | 64 | Binary64 operand |
| dz_mode | input | 1 | Treat zero-exponent operands as zero |
| res_out | output | 64 | Binary64 exponent result, registered |
| flag_inv | output | 1 | Operand was a signaling NaN |
| flag_den | output | 1 | Operand was a subnormal that was normalized |

## Verification
The bench sweeps every exponent field under both signs and both denormals-as-zero settings. It also walks the leading one of a subnormal fraction through all 52 positions, so a leading-zero count that is off by one shifts every subnormal result by one. The exponent-1023 case catches a converter that encodes zero as a normalized value instead of the all-zero word. The exponent-1022 and exponent-1 cases catch a sign or magnitude error in the negative-integer path. Quiet and signaling NaNs with payloads catch a design that drops the payload, does not set the quiet bit, or raises invalid on a quiet NaN. Applying flag-raising operands next to clean ones exposes a flag that stays stuck high.

// File: rtl/dexp_pkg.sv
package dexp_pkg;
  localparam int WORD_W = 64;
  localparam int EXP_W  = 11;
  localparam int FRAC_W = 52;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  // signed integer width: covers -(BIAS + FRAC_W - 1) .. BIAS
  localparam int INT_W  = EXP_W + 1;

  // remove the bias from a normal exponent field
  function automatic logic [INT_W-1:0] f_unbias(input logic [EXP_W-1:0] e);
    return INT_W'(int'(e) - BIAS);
  endfunction

  // exponent of a subnormal given the leading-zero count of its fraction
  function automatic logic [INT_W-1:0] f_sub_exp(input int lz);
    return INT_W'(-BIAS - lz);
  endfunction
endpackage

// File: rtl/dexp_lzc.sv
module dexp_lzc #(
  parameter int W  = 52,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] zeros
);
  // the highest set bit wins because the loop runs upward
  always_comb begin
    zeros = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) zeros = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/dexp_classify.sv
module dexp_classify
  import dexp_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int FW = FRAC_W
) (
  input  logic [EW+FW-1:0] mag,   // operand without its sign
  input  logic             dz,
  output logic             c_nan,
  output logic             c_snan,
  output logic             c_inf,
  output logic             c_zero,
  output logic             c_sub,
  output logic             c_norm
);
  logic [EW-1:0] e;
  logic [FW-1:0] f;
  logic e_max, e_min, f_nz;

  assign e     = mag[FW +: EW];
  assign f     = mag[FW-1:0];
  assign e_max = &e;
  assign e_min = ~|e;
  assign f_nz  = |f;

  assign c_nan  = e_max & f_nz;
  assign c_snan = c_nan & ~f[FW-1];
  assign c_inf  = e_max & ~f_nz;
  assign c_zero = e_min & (~f_nz | dz);
  assign c_sub  = e_min & f_nz & ~dz;
  assign c_norm = ~e_max & ~e_min;
endmodule

// File: rtl/dexp_int2fp.sv
module dexp_int2fp
  import dexp_pkg::*;
#(
  parameter int IW = INT_W,
  parameter int EW = EXP_W,
  parameter int FW = FRAC_W,
  parameter int BS = BIAS,
  localparam int CW = $clog2(IW + 1)
) (
  input  logic [IW-1:0]    ival,   // two's complement
  output logic [EW+FW:0]   word
);
  logic          neg;
  logic [IW-1:0] amag;
  logic [CW-1:0] lz;
  logic [IW-1:0] nrm;
  logic [EW-1:0] ex;
  logic [FW-1:0] fr;

  assign neg  = ival[IW-1];
  assign amag = neg ? (~ival + 1'b1) : ival;

  dexp_lzc #(.W(IW), .CW(CW)) u_lzc (.vec(amag), .zeros(lz));

  // leading one moves to the top bit, then it is dropped as the hidden bit
  assign nrm  = amag << lz;
  assign ex   = EW'(BS + IW - 1 - int'(lz));
  assign fr   = {nrm[IW-2:0], {(FW - IW + 1){1'b0}}};
  assign word = (amag == '0) ? '0 : {neg, ex, fr};
endmodule

// File: rtl/dexp_unit.sv
module dexp_unit
  import dexp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] op_in,
  input  logic              dz_mode,
  output logic [WORD_W-1:0] res_out,
  output logic              flag_inv,
  output logic              flag_den
);
  localparam int LZW = $clog2(FRAC_W + 1);
  localparam logic [WORD_W-1:0] POS_INF = {1'b0, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  localparam logic [WORD_W-1:0] NEG_INF = {1'b1, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};

  logic c_nan, c_snan, c_inf, c_zero, c_sub, c_norm;
  logic [LZW-1:0]    frac_lz;
  logic [INT_W-1:0]  int_exp;
  logic [WORD_W-1:0] conv_word;
  logic [WORD_W-1:0] res_d;
  logic [WORD_W-1:0] res_q;
  logic              inv_q, den_q, seen_q;

  dexp_classify u_cls (
    .mag   (op_in[WORD_W-2:0]),
    .dz    (dz_mode),
    .c_nan (c_nan),
    .c_snan(c_snan),
    .c_inf (c_inf),
    .c_zero(c_zero),
    .c_sub (c_sub),
    .c_norm(c_norm)
  );

  dexp_lzc #(.W(FRAC_W), .CW(LZW)) u_frac_lzc (
    .vec  (op_in[FRAC_W-1:0]),
    .zeros(frac_lz)
  );

  always_comb begin
    int_exp = '0;
    if (c_sub)       int_exp = f_sub_exp(int'(frac_lz));
    else if (c_norm) int_exp = f_unbias(op_in[FRAC_W +: EXP_W]);
  end

  dexp_int2fp u_conv (.ival(int_exp), .word(conv_word));

  always_comb begin
    if (c_nan)       res_d = op_in | (WORD_W'(1) << (FRAC_W - 1));
    else if (c_inf)  res_d = POS_INF;
    else if (c_zero) res_d = NEG_INF;
    else             res_d = conv_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q  <= '0;
      inv_q  <= 1'b0;
      den_q  <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      res_q  <= res_d;
      inv_q  <= c_snan;
      den_q  <= c_sub;
      seen_q <= 1'b1;
    end
  end

  assign res_out  = res_q;
  assign flag_inv = inv_q;
  assign flag_den = den_q;

  // exactly one operand class is active
  p_one_class_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({c_nan, c_inf, c_zero, c_sub, c_norm}));

  p_sign_by_exp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(c_norm | c_sub)) |->
      res_out[WORD_W-1] == ($past(op_in[FRAC_W +: EXP_W]) < EXP_W'(BIAS)));

  p_inv_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flag_inv |-> (&res_out[FRAC_W-1 +: EXP_W+1]));

  p_inf_pos_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(c_inf)) |-> res_out == POS_INF);

  p_zero_neginf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(c_zero)) |-> (res_out == NEG_INF && !flag_den && !flag_inv));

  p_den_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> flag_den == $past(c_sub));

  p_daz_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(dz_mode && op_in[FRAC_W +: EXP_W] == '0)) |->
      (res_out == NEG_INF && !flag_den));

  p_unit_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(op_in[FRAC_W +: EXP_W] == EXP_W'(BIAS))) |-> res_out == '0);

  p_int_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    c_sub |-> ($signed(int_exp) <= -BIAS && $signed(int_exp) >= -(BIAS + FRAC_W - 1)));
endmodule

// File: tb/dexp_unit_tb.sv
module dexp_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] op = '0;
  logic        daz = 1'b0;
  logic [63:0] res_out;
  logic        flag_inv, flag_den;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  dexp_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_in(op), .dz_mode(daz),
    .res_out(res_out), .flag_inv(flag_inv), .flag_den(flag_den)
  );

  // independent model: integer exponent found by searching bits, converted by the simulator
  function automatic logic [63:0] ref_model(input logic [63:0] x, input logic d,
                                            output logic inv, output logic den,
                                            output string tag);
    int e = int'(x[62:52]);
    logic [51:0] f = x[51:0];
    int k, pos;
    inv = 1'b0; den = 1'b0;
    if (e == 2047) begin
      if (f != 0) begin
        inv = ~f[51]; tag = "R3";
        return {x[63:52], 1'b1, x[50:0]};
      end
      tag = "R4";
      return 64'h7FF0000000000000;
    end
    if (e == 0) begin
      if (f == 0 || d) begin
        tag = (f == 0) ? "R5" : "R7";
        return 64'hFFF0000000000000;
      end
      pos = 0;
      for (int b = 0; b < 52; b++) if (f[b]) pos = b;
      k = pos - 1074; den = 1'b1; tag = "R6";
      return $realtobits(real'(k));
    end
    k = e - 1023;
    tag = (k == 0) ? "R8" : (x[63] ? "R2" : "R1");
    return $realtobits(real'(k));
  endfunction

  task automatic apply(input logic [63:0] x, input logic d);
    logic [63:0] exp_r;
    logic ei, ed;
    string tag;
    @(negedge clk);
    op = x; daz = d;
    exp_r = ref_model(x, d, ei, ed, tag);
    @(negedge clk);   // one register: result visible after the next edge (R10)
    n_chk++;
    if (res_out !== exp_r) begin
      n_bad++;
      $display("FAIL %s op=%h daz=%0b result %h expected %h", tag, x, d, res_out, exp_r);
    end
    n_chk++;
    if (flag_inv !== ei || flag_den !== ed) begin
      n_bad++;
      $display("FAIL R9/%s op=%h flags inv=%0b den=%0b expected inv=%0b den=%0b",
               tag, x, flag_inv, flag_den, ei, ed);
    end
  endtask

  initial begin
    logic [51:0] fr [4];
    fr[0] = 52'h0; fr[1] = 52'h1; fr[2] = 52'h8000000000000; fr[3] = 52'h123456789ABCD;
    op = 64'h7FF4000000000000; daz = 1'b1;
    repeat (3) @(negedge clk);
    // R10: reset state
    n_chk++;
    if (res_out !== 64'h0 || flag_inv !== 1'b0 || flag_den !== 1'b0) begin
      n_bad++;
      $display("FAIL R10 reset result %h inv=%0b den=%0b expected 0 0 0", res_out, flag_inv, flag_den);
    end
    rst_n = 1'b1;
    // R1 R2 R4 R5 R7 R8 R3: every exponent, both signs, both modes
    for (int e = 0; e < 2048; e++)
      for (int fi = 0; fi < 4; fi++)
        for (int s = 0; s < 2; s++)
          for (int d = 0; d < 2; d++)
            apply({s[0], e[10:0], fr[fi]}, d[0]);
    // R6: leading one at every fraction position, with and without trailing bits
    for (int p = 0; p < 52; p++) begin
      apply({1'b0, 11'd0, 52'(64'd1 << p)}, 1'b0);
      apply({1'b1, 11'd0, 52'((64'd1 << p) | ((64'd1 << p) - 1))}, 1'b0);
      apply({1'b0, 11'd0, 52'(64'd1 << p)}, 1'b1);   // R7
    end
    // R9: flag-raising operands directly followed by clean ones
    apply(64'h7FF0000000000001, 1'b0);
    apply(64'h3FF0000000000000, 1'b0);
    apply(64'h0000000000000010, 1'b0);
    apply(64'h4000000000000000, 1'b0);
    apply(64'hFFF8DEADBEEF0000, 1'b0);
    apply(64'h8000000000000000, 1'b0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired result %h expected completion", res_out);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule